// File: doc/BRIEF.md
# Bit-Centre Sampling Clock Recovery Loop

This block recovers a sampling clock for a slow serial receive stream that has already been demodulated to a single logic level. It runs from a one-cycle enable pulse (the tick) that arrives sixteen times per bit period. A sixteen-step phase counter drives the recovered clock output. The counter is forced back to its starting phase whenever the received level changes, so the falling edge of the recovered clock lands in the middle of each bit. On that falling edge the received level is captured into the data output.

A mode input bypasses the loop. A second counter starts at reset and advances on every tick, and it never takes notice of the data. When the mode input is high, both the clock output and the capture instant come from this free-running counter. The received line passes through a flop synchronizer before anything compares it. The asynchronous active-low reset is released through a local synchronizer.

Top module: `bitsync_dpll`

## Requirements
- R1: After reset, the clock output is high, the data output is 0, and both the loop counter and the free-running counter are at phase 0.
- R2: Neither counter moves on a clock cycle in which the tick input is low.
- R3: With no change on the received line, the clock output repeats with a period of 16 ticks. It is high while the selected counter is at phases 0 to 7 and low at phases 8 to 15.
- R4: With the mode input low, a received-level change that is detected at a tick sets the loop counter to phase 0. The clock output is then high after that tick, stays high for the following 7 ticks, and falls at the 8th tick after the detecting tick.
- R5: Whatever phase the loop counter held before a detected change, the first falling edge of the clock output after it comes exactly 8 ticks later and never later.
- R6: The data output takes the synchronized received level at the tick where the selected counter moves from phase 7 to phase 8 (the clock output's falling edge). It holds its value at every other cycle.
- R7: With the mode input high, changes on the received line have no effect on either counter. The clock output follows the free-running counter.
- R8: The free-running counter advances on every tick from reset, whatever the mode. A change of the mode input switches the clock output to the selected counter in the same cycle.
- R9: The received line passes through two flops. A change is seen at a tick only if it was present at least two clock edges before that tick's edge. A later change is seen at the next tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_16x | input | 1 | One-cycle enable, sixteen per bit period |
| rx_data_in | input | 1 | Demodulated receive level (asynchronous) |
| free_run | input | 1 | 1 selects the free-running reference; 0 selects the data-locked loop |
| sync_clk_o | output | 1 | Recovered sampling clock; its falling edge marks bit centre |
| rx_data_o | output | 1 | Received level captured at the falling edge of sync_clk_o |

## Verification
The timing counts from when a change reaches the block. The bench applies each line change just after a tick. The two synchronizer flops have settled before the next tick, so that tick detects the change and sets the loop phase. The clock output is observed at the falling clock edge after each tick. It must be high at the detecting tick and for the 7 ticks after it, and low at the 8th. The data output is due on that same 8th tick.

A separate case drives a change in the same cycle as a tick. That change must be seen one tick later. Mode switches are checked in the cycle they are applied, because the output select is combinational. Between ticks, idle clock cycles check that neither counter moves.

// File: rtl/bitsync_pkg.sv
`timescale 1ns/1ps
package bitsync_pkg;

  localparam int unsigned OVERSAMPLE_DEFAULT  = 16;
  localparam int unsigned SYNC_STAGES_DEFAULT = 2;
  localparam int unsigned RST_STAGES_DEFAULT  = 2;

  // Width of a counter holding 0 .. n-1
  function automatic int unsigned phase_bits(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/bitsync_rst_sync.sv
`timescale 1ns/1ps
module bitsync_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_n_o = chain_q[STAGES-1];

endmodule

// File: rtl/bitsync_edge_det.sv
`timescale 1ns/1ps
module bitsync_edge_det #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic din,
  output logic data_sync,
  output logic edge_seen
);

  logic [STAGES-1:0] meta_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) meta_q[0] <= 1'b0;
          else        meta_q[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) meta_q[i] <= 1'b0;
          else        meta_q[i] <= meta_q[i-1];
        end
      end
    end
  endgenerate

  assign data_sync = meta_q[STAGES-1];

  // level seen at the previous tick
  logic last_q;
  logic last_d;

  always_comb begin
    last_d = last_q;
    if (tick) last_d = data_sync;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= last_d;
  end

  assign edge_seen = tick && (data_sync != last_q);

endmodule

// File: rtl/bitsync_phase_ctr.sv
`timescale 1ns/1ps
module bitsync_phase_ctr #(
  parameter int unsigned OVERSAMPLE = 16,
  parameter bit          ALIGN_EN   = 1'b1,
  localparam int unsigned PW        = bitsync_pkg::phase_bits(OVERSAMPLE)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          align,
  output logic [PW-1:0] phase_o,
  output logic          high_o
);

  localparam logic [PW-1:0] LAST = PW'(OVERSAMPLE - 1);
  localparam logic [PW-1:0] HALF = PW'(OVERSAMPLE / 2);

  logic [PW-1:0] phase_q;
  logic [PW-1:0] phase_d;
  logic          align_eff;

  assign align_eff = ALIGN_EN ? align : 1'b0;

  always_comb begin
    phase_d = phase_q;
    if (tick) begin
      if (align_eff)            phase_d = '0;
      else if (phase_q == LAST) phase_d = '0;
      else                      phase_d = phase_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_d;
  end

  assign phase_o = phase_q;
  assign high_o  = (phase_q < HALF);

endmodule

// File: rtl/bitsync_sampler.sv
`timescale 1ns/1ps
module bitsync_sampler #(
  parameter int unsigned PW         = 4,
  parameter int unsigned FALL_PHASE = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [PW-1:0] phase,
  input  logic          din,
  output logic          dout
);

  logic capture;
  logic data_q;
  logic data_d;

  assign capture = tick && (phase == PW'(FALL_PHASE));

  always_comb begin
    data_d = data_q;
    if (capture) data_d = din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) data_q <= 1'b0;
    else        data_q <= data_d;
  end

  assign dout = data_q;

endmodule

// File: rtl/bitsync_dpll.sv
`timescale 1ns/1ps
module bitsync_dpll #(
  parameter int unsigned OVERSAMPLE  = bitsync_pkg::OVERSAMPLE_DEFAULT,
  parameter int unsigned SYNC_STAGES = bitsync_pkg::SYNC_STAGES_DEFAULT,
  parameter int unsigned RST_STAGES  = bitsync_pkg::RST_STAGES_DEFAULT
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_16x,
  input  logic rx_data_in,
  input  logic free_run,
  output logic sync_clk_o,
  output logic rx_data_o
);

  localparam int unsigned PW         = bitsync_pkg::phase_bits(OVERSAMPLE);
  localparam int unsigned FALL_PHASE = OVERSAMPLE / 2 - 1;

  logic          rst_int_n;
  logic          data_sync;
  logic          edge_seen;
  logic          loop_align;
  logic [PW-1:0] loop_phase;
  logic [PW-1:0] ref_phase;
  logic [PW-1:0] sel_phase;
  logic          loop_high;
  logic          ref_high;

  bitsync_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_int_n)
  );

  bitsync_edge_det #(.STAGES(SYNC_STAGES)) u_edge (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .tick      (tick_16x),
    .din       (rx_data_in),
    .data_sync (data_sync),
    .edge_seen (edge_seen)
  );

  assign loop_align = edge_seen && !free_run;

  bitsync_phase_ctr #(.OVERSAMPLE(OVERSAMPLE), .ALIGN_EN(1'b1)) u_loop (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .tick    (tick_16x),
    .align   (loop_align),
    .phase_o (loop_phase),
    .high_o  (loop_high)
  );

  bitsync_phase_ctr #(.OVERSAMPLE(OVERSAMPLE), .ALIGN_EN(1'b0)) u_ref (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .tick    (tick_16x),
    .align   (1'b0),
    .phase_o (ref_phase),
    .high_o  (ref_high)
  );

  assign sel_phase  = free_run ? ref_phase : loop_phase;
  assign sync_clk_o = free_run ? ref_high  : loop_high;

  bitsync_sampler #(.PW(PW), .FALL_PHASE(FALL_PHASE)) u_samp (
    .clk   (clk),
    .rst_n (rst_int_n),
    .tick  (tick_16x),
    .phase (sel_phase),
    .din   (data_sync),
    .dout  (rx_data_o)
  );

endmodule

// File: rtl/bitsync_dpll_checker.sv
`timescale 1ns/1ps
module bitsync_dpll_checker #(
  parameter int unsigned OVERSAMPLE = 16,
  localparam int unsigned PW        = bitsync_pkg::phase_bits(OVERSAMPLE)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick_16x,
  input logic          free_run,
  input logic          edge_seen,
  input logic [PW-1:0] loop_phase,
  input logic [PW-1:0] ref_phase,
  input logic [PW-1:0] sel_phase,
  input logic          rx_data_o
);

  localparam logic [PW-1:0] FALL = PW'(OVERSAMPLE / 2 - 1);
  localparam logic [PW-1:0] LAST = PW'(OVERSAMPLE - 1);

  assert_hold_without_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_16x |=> ($stable(loop_phase) && $stable(ref_phase)));

  assert_ref_moves_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tick_16x |=> (ref_phase != $past(ref_phase)));

  assert_realign_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_16x && edge_seen && !free_run) |=> (loop_phase == '0));

  assert_capture_at_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_data_o != $past(rx_data_o)) |-> ($past(tick_16x) && ($past(sel_phase) == FALL)));

  assert_free_ignores_edges_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_16x && free_run) |=> ((loop_phase != '0) || ($past(loop_phase) == LAST)));

endmodule

bind bitsync_dpll bitsync_dpll_checker #(.OVERSAMPLE(OVERSAMPLE)) u_chk (
  .clk        (clk),
  .rst_n      (rst_int_n),
  .tick_16x   (tick_16x),
  .free_run   (free_run),
  .edge_seen  (edge_seen),
  .loop_phase (loop_phase),
  .ref_phase  (ref_phase),
  .sel_phase  (sel_phase),
  .rx_data_o  (rx_data_o)
);

// File: tb/bitsync_dpll_test.sv
`timescale 1ns/1ps
module bitsync_dpll_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_16x = 1'b0;
  logic rx_data_in = 1'b0;
  logic free_run = 1'b0;
  logic sync_clk_o;
  logic rx_data_o;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // expected-state model built from the requirements
  int m_loop = 0;
  int m_ref = 0;
  logic m_data = 1'b0;
  logic m_last = 1'b0;

  always #5 clk = ~clk;

  bitsync_dpll uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_16x   (tick_16x),
    .rx_data_in (rx_data_in),
    .free_run   (free_run),
    .sync_clk_o (sync_clk_o),
    .rx_data_o  (rx_data_o)
  );

  task automatic check_bit(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic exp_sync();
    return ((free_run ? m_ref : m_loop) < 8);
  endfunction

  // One tick. seen_rx is the line level the synchronizer delivers at this tick.
  // When late is set, the line takes late_val together with the tick pulse.
  task automatic tick_step(input string req, input logic seen_rx, input bit late, input logic late_val);
    int sel;
    bit edge_now;
    repeat (2) @(negedge clk);
    tick_16x = 1'b1;
    if (late) rx_data_in = late_val;
    sel = free_run ? m_ref : m_loop;
    if (sel == 7) m_data = seen_rx;
    edge_now = (seen_rx != m_last);
    m_last = seen_rx;
    m_loop = (!free_run && edge_now) ? 0 : (m_loop + 1) % 16;
    m_ref = (m_ref + 1) % 16;
    @(negedge clk);
    tick_16x = 1'b0;
    check_bit({req, " sync"}, sync_clk_o, exp_sync());
    check_bit({req, " data"}, rx_data_o, m_data);
  endtask

  task automatic tick(input string req);
    tick_step(req, rx_data_in, 1'b0, 1'b0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    check_bit("R1 sync after reset", sync_clk_o, 1'b1);
    check_bit("R1 data after reset", rx_data_o, 1'b0);

    // R2: idle cycles with no tick leave phase untouched
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      check_bit("R2 idle sync", sync_clk_o, 1'b1);
    end
    tick("R2");

    // R3: free running loop, constant line
    for (int i = 0; i < 40; i++) tick("R3");

    // R2 again in mid-period: idle clocks while low
    while (m_loop != 10) tick("R3");
    for (int i = 0; i < 15; i++) begin
      @(negedge clk);
      check_bit("R2 idle mid", sync_clk_o, 1'b0);
    end

    // R4/R5: realign from every prior phase
    for (int ph = 0; ph < 16; ph++) begin
      while (m_loop != ph) tick("R5 approach");
      rx_data_in = ~rx_data_in;
      tick("R4 detect");
      check_bit("R4 high at detect", sync_clk_o, 1'b1);
      for (int k = 1; k <= 7; k++) begin
        tick("R5 hold");
        check_bit("R5 still high", sync_clk_o, 1'b1);
      end
      tick("R5 fall");
      check_bit("R5 falls at 8", sync_clk_o, 1'b0);
      check_bit("R6 captured at fall", rx_data_o, rx_data_in);
    end

    // R6: data stream, one bit per 16 ticks
    for (int b = 0; b < 24; b++) begin
      rx_data_in = logic'((b * 5 + 3) % 7 > 2);
      for (int k = 0; k < 16; k++) tick("R6");
    end

    // R7: free_run ignores transitions
    free_run = 1'b1;
    @(negedge clk);
    check_bit("R8 switch to ref", sync_clk_o, logic'(m_ref < 8));
    for (int i = 0; i < 48; i++) begin
      if (i % 5 == 2) rx_data_in = ~rx_data_in;
      tick("R7");
    end

    // R8: switch back and forth; ref keeps counting
    free_run = 1'b0;
    @(negedge clk);
    check_bit("R8 switch to loop", sync_clk_o, logic'(m_loop < 8));
    for (int i = 0; i < 5; i++) tick("R8");
    free_run = 1'b1;
    @(negedge clk);
    check_bit("R8 ref again", sync_clk_o, logic'(m_ref < 8));
    tick("R8");
    free_run = 1'b0;
    for (int i = 0; i < 20; i++) tick("R8");

    // R9: change arriving with the tick is seen one tick later
    while (m_loop != 3) tick("R9 approach");
    begin
      logic old_v;
      logic new_v;
      old_v = rx_data_in;
      new_v = ~old_v;
      tick_step("R9 late", old_v, 1'b1, new_v);
      check_bit("R9 not yet realigned", sync_clk_o, 1'b1);
      tick("R9 seen");
      check_bit("R9 realigned next tick", sync_clk_o, 1'b1);
      for (int k = 0; k < 10; k++) tick("R9 after");
    end

    finish_run();
  end

endmodule